// File: doc/BRIEF.md
# Shared Serial Port Access Controller

This block lets several client threads share one serial transmitter and one serial receiver. The threads take turns on the transmitter through a lock. A thread requests the lock, keeps it for as long as it likes, and hands it back by releasing it. While a thread holds the lock, only that thread's valid byte can start a transmit frame. Bytes that other threads present at the same time are dropped. The transmit side has no queue. A writer watches `wr_ready_o` and offers a byte only when the transmitter is idle.

On the receive side, each good frame lands in a read queue, and any thread pops bytes from its head. The receiver may start a new frame only while the transmitter is idle and the queue has room. The enable is brought out on `rx_en_o`, so the far end can hold off while this side is busy. The line format is one low start bit, eight data bits sent least significant first, and one high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles. The line rests high.

Top module: `uart_access_ctrl`

## Requirements
- R1: After reset no thread holds the lock (`lock_grant_o` all zero), `wr_ready_o` is 1, `tx_o` is 1, `rd_empty_o` is 1, `rd_full_o` is 0 and `rx_en_o` is 1.
- R2: While the lock is free, a cycle with any bit of `lock_req_i` set grants the lock to the lowest-numbered requester. The grant shows from the next cycle as bit i of `lock_grant_o`, and at most one bit of `lock_grant_o` is ever set.
- R3: The holder keeps the lock through requests from other threads and through releases from threads that do not hold it. A release from the holder leaves `lock_grant_o` all zero from the next cycle.
- R4: A transmit frame starts only in a cycle where the holder asserts its bit of `wr_valid_i` while `wr_ready_o` is 1. The frame carries the holder's byte, `wr_data_i[8*i+7:8*i]` for thread i. A valid byte from any other thread never starts a frame.
- R5: A frame on `tx_o` is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts `CLKS_PER_BIT` cycles, and the start bit begins in the cycle after the byte is accepted. Between frames `tx_o` is 1.
- R6: `wr_ready_o` is 1 exactly while the transmitter is idle. It goes to 0 in the cycle after acceptance and returns to 1 after the full stop bit.
- R7: Each received frame with a high stop bit is appended to the read queue. `rd_data_o` shows the oldest byte, and `rd_pop_i` removes it, so bytes leave in arrival order.
- R8: `rx_en_o` is 1 only while the transmitter is idle and the queue is not full. A frame whose start bit arrives while `rx_en_o` is 0 is never stored.
- R9: `rd_pop_i` on an empty queue changes nothing: no flag changes, and the next stored byte is still read out correctly.
- R10: The queue holds `RD_DEPTH` bytes, a power of two. `rd_full_o` is 1 exactly when `RD_DEPTH` bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_req_i | input | N_THREADS | Per-thread transmit lock request |
| lock_rel_i | input | N_THREADS | Per-thread transmit lock release |
| lock_grant_o | output | N_THREADS | One-hot lock holder, all zero when free |
| wr_valid_i | input | N_THREADS | Per-thread byte valid |
| wr_data_i | input | 8*N_THREADS | Per-thread byte, thread i in bits 8i+7:8i |
| wr_ready_o | output | 1 | Transmitter idle |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_en_o | output | 1 | Receiver allowed to start a frame |
| rd_pop_i | input | 1 | Pop the head of the read queue |
| rd_data_o | output | 8 | Head of the read queue |
| rd_empty_o | output | 1 | Read queue empty |
| rd_full_o | output | 1 | Read queue full |

## Verification
A wrong lock state shows on `lock_grant_o` in the cycle after the request or release that exposed it. It also shows on `tx_o` within one bit time, because a frame starts from the wrong thread or does not start. A wrong transmitter state shows on `wr_ready_o` and on the sampled line bits within one frame. A wrong read-queue pointer shows when the next byte is popped, either as a wrong `rd_data_o` or as an empty or full flag that disagrees with the count of bytes sent and popped. The bench sweeps every request pattern for four threads and walks the queue through empty, full and overflow.

// File: rtl/uac_pkg.sv
package uac_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uac_lock_arb.sv
module uac_lock_arb #(
  parameter int N_THREADS = 4,
  localparam int IDX_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] req_i,
  input  logic [N_THREADS-1:0] rel_i,
  output logic                 held_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [N_THREADS-1:0] grant_o
);
  logic             held_q, held_d;
  logic [IDX_W-1:0] idx_q, idx_d, low_idx;

  // lowest-numbered requester wins
  always_comb begin
    low_idx = '0;
    for (int i = N_THREADS - 1; i >= 0; i--) begin
      if (req_i[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    held_d = held_q;
    idx_d  = idx_q;
    if (!held_q) begin
      if (|req_i) begin
        held_d = 1'b1;
        idx_d  = low_idx;
      end
    end else if (rel_i[idx_q]) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      held_q <= held_d;
      idx_q  <= idx_d;
    end
  end

  for (genvar g = 0; g < N_THREADS; g++) begin : g_grant
    assign grant_o[g] = held_q && (idx_q == IDX_W'(g));
  end

  assign held_o = held_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/uac_tx.sv
module uac_tx
  import uac_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  byte_t data_i,
  output logic  idle_o,
  output logic  line_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  byte_t            sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          state_q <= TX_START;
          cnt_q   <= '0;
          sh_q    <= data_i;
        end
        TX_START: begin
          if (cnt_q == LAST) begin
            state_q <= TX_DATA;
            cnt_q   <= '0;
            bit_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {1'b0, sh_q[7:1]};
            if (bit_q == 3'd7) state_q <= TX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_STOP: begin
          if (cnt_q == LAST) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: line_o = 1'b0;
      TX_DATA:  line_o = sh_q[0];
      default:  line_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == TX_IDLE);
endmodule

// File: rtl/uac_rx.sv
module uac_rx
  import uac_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1),
  localparam int HALF  = CLKS_PER_BIT / 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  line_i,
  output logic  valid_o,
  output byte_t data_o
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID   = CNT_W'(HALF - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  byte_t            sh_q;
  logic [1:0]       sync_q;
  logic             valid_q;
  logic             s;

  assign s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_i};
      valid_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (en_i && !s) begin
          state_q <= RX_START;
          cnt_q   <= '0;
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= s ? RX_IDLE : RX_DATA;  // reject a glitch
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {s, sh_q[7:1]};
            if (bit_q == 3'd7) state_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            valid_q <= s;
            state_q <= RX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/uac_fifo.sv
module uac_fifo
  import uac_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  byte_t data_i,
  input  logic  pop_i,
  output byte_t data_o,
  output logic  empty_o,
  output logic  full_o
);
  byte_t       mem_q [DEPTH];
  logic [AW:0] wptr_q, rptr_q;
  logic        do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/uart_access_ctrl.sv
module uart_access_ctrl
  import uac_pkg::*;
#(
  parameter int N_THREADS    = 4,
  parameter int CLKS_PER_BIT = 4,
  parameter int RD_DEPTH     = 16,
  localparam int IDX_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_THREADS-1:0]   lock_req_i,
  input  logic [N_THREADS-1:0]   lock_rel_i,
  output logic [N_THREADS-1:0]   lock_grant_o,
  input  logic [N_THREADS-1:0]   wr_valid_i,
  input  logic [8*N_THREADS-1:0] wr_data_i,
  output logic                   wr_ready_o,
  output logic                   tx_o,
  input  logic                   rx_i,
  output logic                   rx_en_o,
  input  logic                   rd_pop_i,
  output logic [7:0]             rd_data_o,
  output logic                   rd_empty_o,
  output logic                   rd_full_o
);
  logic             held;
  logic [IDX_W-1:0] idx;
  logic             tx_idle, tx_start;
  byte_t            tx_byte;
  logic             rx_valid;
  byte_t            rx_byte;

  uac_lock_arb #(.N_THREADS(N_THREADS)) arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (lock_req_i),
    .rel_i  (lock_rel_i),
    .held_o (held),
    .idx_o  (idx),
    .grant_o(lock_grant_o)
  );

  assign tx_byte  = wr_data_i[8*idx +: 8];
  assign tx_start = held && wr_valid_i[idx] && tx_idle;

  uac_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .data_i (tx_byte),
    .idle_o (tx_idle),
    .line_o (tx_o)
  );

  assign wr_ready_o = tx_idle;
  assign rx_en_o    = tx_idle && !rd_full_o;

  uac_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_o),
    .line_i (rx_i),
    .valid_o(rx_valid),
    .data_o (rx_byte)
  );

  uac_fifo #(.DEPTH(RD_DEPTH)) fifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_valid),
    .data_i (rx_byte),
    .pop_i  (rd_pop_i),
    .data_o (rd_data_o),
    .empty_o(rd_empty_o),
    .full_o (rd_full_o)
  );
endmodule

// File: rtl/uac_chk.sv
module uac_chk #(
  parameter int N_THREADS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_THREADS-1:0] lock_rel_i,
  input logic [N_THREADS-1:0] lock_grant_o,
  input logic [N_THREADS-1:0] wr_valid_i,
  input logic                 wr_ready_o,
  input logic                 tx_o,
  input logic                 rd_pop_i,
  input logic [7:0]           rd_data_o,
  input logic                 rd_full_o
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lock_grant_o));

  // R3
  hold_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lock_grant_o) && !(|(lock_grant_o & lock_rel_i)) |=> lock_grant_o == $past(lock_grant_o));

  // R3
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lock_grant_o & lock_rel_i)) |=> lock_grant_o == '0);

  // R4
  start_by_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_ready_o) |-> $past(|(lock_grant_o & wr_valid_i)));

  // R5
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> tx_o);

  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_full_o && !rd_pop_i |=> rd_full_o && $stable(rd_data_o));
endmodule

bind uart_access_ctrl uac_chk #(.N_THREADS(N_THREADS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_rel_i  (lock_rel_i),
  .lock_grant_o(lock_grant_o),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .tx_o        (tx_o),
  .rd_pop_i    (rd_pop_i),
  .rd_data_o   (rd_data_o),
  .rd_full_o   (rd_full_o)
);

// File: tb/uart_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_access_ctrl_tb_top;
  localparam int N = 4;
  localparam int C = 4;
  localparam int D = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   lock_req_i = '0, lock_rel_i = '0, lock_grant_o;
  logic [N-1:0]   wr_valid_i = '0;
  logic [8*N-1:0] wr_data_i = '0;
  logic           wr_ready_o, tx_o, rx_en_o, rd_empty_o, rd_full_o;
  logic           rx_i = 1'b1, rd_pop_i = 1'b0;
  logic [7:0]     rd_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_access_ctrl #(.N_THREADS(N), .CLKS_PER_BIT(C), .RD_DEPTH(D)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  function automatic logic [N-1:0] low_bit(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic take(input int t);
    lock_req_i = N'(1) << t;
    nclk(1);
    lock_req_i = '0;
  endtask

  task automatic drop(input int t);
    lock_rel_i = N'(1) << t;
    nclk(1);
    lock_rel_i = '0;
  endtask

  // decode one frame on tx_o, starting at the negedge showing the start bit
  task automatic tx_decode(input logic [7:0] exp, input string tag);
    logic [7:0] got;
    logic st, sp;
    nclk(C/2);
    st = tx_o;
    for (int i = 0; i < 8; i++) begin
      nclk(C);
      got[i] = tx_o;
    end
    nclk(C);
    sp = tx_o;
    chk(st == 1'b0 && sp == 1'b1 && got == exp, tag, {st, got, sp}, {1'b0, exp, 1'b1});
    for (int k = 0; k < 40 && !wr_ready_o; k++) nclk(1);
    chk(wr_ready_o && tx_o, "R6 ready after stop", {wr_ready_o, tx_o}, 2'b11);
  endtask

  task automatic rx_send(input logic [7:0] b);
    rx_i = 1'b0; nclk(C);
    for (int i = 0; i < 8; i++) begin rx_i = b[i]; nclk(C); end
    rx_i = 1'b1; nclk(C);
    nclk(4);
  endtask

  task automatic pop_expect(input logic [7:0] b, input string tag);
    chk(!rd_empty_o && rd_data_o == b, tag, {rd_empty_o, rd_data_o}, {1'b0, b});
    rd_pop_i = 1'b1; nclk(1); rd_pop_i = 1'b0;
  endtask

  initial begin
    nclk(2);
    chk(lock_grant_o == '0 && wr_ready_o && tx_o && rd_empty_o && !rd_full_o && rx_en_o,
        "R1 reset", {lock_grant_o, wr_ready_o, tx_o, rd_empty_o, rd_full_o, rx_en_o}, 9'b0000_11101);
    rst_ni = 1'b1;
    nclk(2);

    // lock sweep over every request pattern
    for (int m = 1; m < (1 << N); m++) begin
      lock_req_i = N'(m); nclk(1); lock_req_i = '0;
      chk(lock_grant_o == low_bit(N'(m)), "R2 lowest wins", lock_grant_o, low_bit(N'(m)));
      lock_rel_i = ~low_bit(N'(m)); nclk(1); lock_rel_i = '0;
      chk(lock_grant_o == low_bit(N'(m)), "R3 foreign release", lock_grant_o, low_bit(N'(m)));
      lock_req_i = '1; nclk(1); lock_req_i = '0;
      chk(lock_grant_o == low_bit(N'(m)), "R3 no steal", lock_grant_o, low_bit(N'(m)));
      lock_rel_i = low_bit(N'(m)); nclk(1); lock_rel_i = '0;
      chk(lock_grant_o == '0, "R3 release frees", lock_grant_o, 0);
    end

    // no holder: valid bytes go nowhere
    wr_valid_i = '1; nclk(3); wr_valid_i = '0;
    chk(wr_ready_o && tx_o, "R4 no holder drop", {wr_ready_o, tx_o}, 2'b11);

    for (int t = 0; t < N; t++) begin
      take(t);
      // R4: non-holders only
      wr_valid_i = ~(N'(1) << t); wr_data_i = '0; nclk(3); wr_valid_i = '0;
      chk(wr_ready_o && tx_o, "R4 non-holder drop", {wr_ready_o, tx_o}, 2'b11);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] b;
        b = 8'(t * 73 + k * 29 + 5);
        for (int j = 0; j < N; j++) wr_data_i[8*j +: 8] = (j == t) ? b : ~b;
        wr_valid_i = '1; nclk(1); wr_valid_i = '0;
        chk(!wr_ready_o, "R6 busy after accept", wr_ready_o, 0);
        chk(!rx_en_o, "R8 rx off while tx", rx_en_o, 0);
        tx_decode(b, "R5 R4 frame");
      end
      drop(t);
    end

    // R7 fill, R10 full, R8 overflow frame lost
    for (int k = 0; k < D; k++) rx_send(8'(k * 51 + 17));
    chk(rd_full_o && !rx_en_o, "R10 full at depth", {rd_full_o, rx_en_o}, 2'b10);
    rx_send(8'h3C);
    for (int k = 0; k < D; k++) pop_expect(8'(k * 51 + 17), "R7 order");
    chk(rd_empty_o && !rd_full_o, "R8 overflow lost", {rd_empty_o, rd_full_o}, 2'b10);

    // R9 pop on empty
    rd_pop_i = 1'b1; nclk(3); rd_pop_i = 1'b0;
    chk(rd_empty_o && !rd_full_o, "R9 empty pop", {rd_empty_o, rd_full_o}, 2'b10);
    rx_send(8'h96);
    rx_send(8'h00);
    pop_expect(8'h96, "R9 after empty pop");
    pop_expect(8'hFF ^ 8'hFF, "R7 second");
    chk(rd_empty_o, "R7 drained", rd_empty_o, 1);

    // R8 frame start during tx is ignored
    take(2);
    wr_data_i[16 +: 8] = 8'h5A; wr_valid_i = 4'b0100; nclk(1); wr_valid_i = '0;
    rx_i = 1'b0; nclk(C); rx_i = 1'b1;
    for (int k = 0; k < 60 && !wr_ready_o; k++) nclk(1);
    nclk(3 * C);
    chk(rd_empty_o, "R8 rx blocked by tx", rd_empty_o, 1);
    drop(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule